// File: doc/BRIEF.md
# Look-up table stuck-at fault list generator

This block takes the 16-bit truth table of a four-input look-up table and works out which of its inputs really influence the output. For the output and for each input that matters, it derives the truth tables that model the output or input stuck at 0 and stuck at 1. Fault cases that give the same 16-bit table are merged into one entry, so each distinct injection table appears only once.

A table is accepted with a one-cycle load strobe. After a fixed build phase, the block emits a valid/ready stream. Each beat carries an injection table, a 10-bit mask naming every fault merged into that entry, and a last flag on the final beat. The number of active inputs of the loaded table is available for as long as that table is held.

Top module: `lut_fault_lister`

## Requirements
- R1: Bit k of the table holds the output for the input combination k = {i3,i2,i1,i0}. Input ix is active when, for at least one setting of the other three inputs, the bit with ix=0 differs from the bit with ix=1. `active_count` reports how many inputs are active, starting from the cycle after the load is accepted.
- R2: The fault set always includes output stuck-at-0 and output stuck-at-1. It also includes stuck-at-0 and stuck-at-1 for each active input, and no fault on an inactive input. Across one stream, the union of the masks is exactly this set.
- R3: The injection table for output stuck-at-v has all 16 bits equal to v.
- R4: The injection table for input x stuck-at-v has, at every index k, the original bit taken from index k with bit x forced to v.
- R5: Faults with identical injection tables share one entry. No two entries of a stream carry the same table, and every emitted mask is non-zero.
- R6: Mask bit 0 is output stuck-at-0 and bit 1 is output stuck-at-1. Bit 2+2x is input x stuck-at-0 and bit 3+2x is input x stuck-at-1.
- R7: Entries leave in increasing order of their lowest-numbered member fault. Only the final entry has `out_last` set, and `out_valid` drops after that entry is taken.
- R8: A load that arrives while a table is still being built or streamed is ignored. Neither the stream nor `active_count` changes, and no second stream follows.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_vector`, `out_mask` and `out_last` keep their values.
- R10: After reset, `out_valid` is low and `active_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Accept `table_in` when the block is idle |
| table_in | input | 16 | Truth table, bit k is the output for combination k |
| out_valid | output | 1 | An entry is presented |
| out_ready | input | 1 | The consumer takes the entry this cycle |
| out_vector | output | 16 | Injection truth table of the entry |
| out_mask | output | 10 | Faults merged into the entry |
| out_last | output | 1 | Final entry of the stream |
| active_count | output | 3 | Number of active inputs of the held table |

## Verification
The hold property assumes that the consumer only lowers `out_ready` to stall, and that it never changes `table_in` or `load` in a way that could restart a stream. The block guarantees the second point by gating loads, and the bench sends a stray load mid-stream to confirm that gating. The property on mask contents assumes the held table is stable during the stream. The bench drives all inputs at falling edges, so every load is a clean one-cycle strobe and ready changes only between handshakes.

// File: rtl/lut_flt_pkg.sv
package lut_flt_pkg;
    localparam int N_IN  = 4;
    localparam int TBL_W = 1 << N_IN;
    localparam int N_FLT = 2 + 2 * N_IN;
    localparam int IDX_W = $clog2(N_FLT + 1);
    localparam int CNT_W = $clog2(N_IN + 1);

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_EMIT    = 2'd2
    } phase_e;
endpackage

// File: rtl/lut_input_probe.sv
module lut_input_probe
    import lut_flt_pkg::*;
(
    input  logic [TBL_W-1:0] tbl,
    output logic [N_IN-1:0]  active,
    output logic [CNT_W-1:0] count
);
    for (genvar x = 0; x < N_IN; x++) begin : g_in
        logic [TBL_W-1:0] diff;
        for (genvar k = 0; k < TBL_W; k++) begin : g_bit
            if (((k >> x) & 1) == 0) begin : g_low
                assign diff[k] = tbl[k] ^ tbl[k + (1 << x)];
            end else begin : g_high
                assign diff[k] = 1'b0;
            end
        end
        assign active[x] = |diff;
    end

    always_comb begin
        count = '0;
        for (int x = 0; x < N_IN; x++) begin
            count = count + CNT_W'(active[x]);
        end
    end
endmodule

// File: rtl/lut_inject_gen.sv
module lut_inject_gen
    import lut_flt_pkg::*;
(
    input  logic [TBL_W-1:0]            tbl,
    input  logic [N_IN-1:0]             active,
    output logic [N_FLT-1:0][TBL_W-1:0] fvec,
    output logic [N_FLT-1:0]            fen
);
    assign fvec[0] = '0;
    assign fvec[1] = '1;
    assign fen[0]  = 1'b1;
    assign fen[1]  = 1'b1;

    for (genvar x = 0; x < N_IN; x++) begin : g_in
        for (genvar v = 0; v < 2; v++) begin : g_val
            localparam int F = 2 + 2 * x + v;
            assign fen[F] = active[x];
            for (genvar k = 0; k < TBL_W; k++) begin : g_bit
                localparam int SRC = (v == 1) ? (k | (1 << x)) : (k & ~(1 << x));
                assign fvec[F][k] = tbl[SRC];
            end
        end
    end
endmodule

// File: rtl/lut_fault_lister.sv
module lut_fault_lister
    import lut_flt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [15:0]      table_in,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [15:0]      out_vector,
    output logic [9:0]       out_mask,
    output logic             out_last,
    output logic [2:0]       active_count
);
    localparam logic [IDX_W-1:0] ONE  = IDX_W'(1);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_FLT - 1);

    typedef struct packed {
        phase_e                         ph;
        logic [TBL_W-1:0]               tbl;
        logic [IDX_W-1:0]               fidx;
        logic [IDX_W-1:0]               nkept;
        logic [IDX_W-1:0]               eidx;
        logic [N_FLT-1:0][TBL_W-1:0]    kvec;
        logic [N_FLT-1:0][N_FLT-1:0]    kmask;
    } lister_t;

    lister_t q, d;

    logic [N_IN-1:0]             active;
    logic [CNT_W-1:0]            count;
    logic [N_FLT-1:0][TBL_W-1:0] fvec;
    logic [N_FLT-1:0]            fen;
    logic [TBL_W-1:0]            cand;
    logic                        hit;

    lut_input_probe u_probe (
        .tbl    (q.tbl),
        .active (active),
        .count  (count)
    );

    lut_inject_gen u_gen (
        .tbl    (q.tbl),
        .active (active),
        .fvec   (fvec),
        .fen    (fen)
    );

    always_comb begin
        d    = q;
        cand = fvec[q.fidx];
        hit  = 1'b0;
        case (q.ph)
            ST_IDLE: begin
                if (load) begin
                    d.tbl   = table_in;
                    d.ph    = ST_COLLECT;
                    d.fidx  = '0;
                    d.nkept = '0;
                    d.eidx  = '0;
                    d.kvec  = '0;
                    d.kmask = '0;
                end
            end
            ST_COLLECT: begin
                if (fen[q.fidx]) begin
                    for (int j = 0; j < N_FLT; j++) begin
                        if (!hit && (IDX_W'(j) < q.nkept) && (q.kvec[j] == cand)) begin
                            d.kmask[j][q.fidx] = 1'b1;
                            hit = 1'b1;
                        end
                    end
                    if (!hit) begin
                        d.kvec[q.nkept]          = cand;
                        d.kmask[q.nkept]         = '0;
                        d.kmask[q.nkept][q.fidx] = 1'b1;
                        d.nkept                  = q.nkept + ONE;
                    end
                end
                d.fidx = q.fidx + ONE;
                if (q.fidx == LAST) begin
                    d.ph = ST_EMIT;
                end
            end
            ST_EMIT: begin
                if (out_ready) begin
                    if (q.eidx == q.nkept - ONE) begin
                        d.ph = ST_IDLE;
                    end else begin
                        d.eidx = q.eidx + ONE;
                    end
                end
            end
            default: d.ph = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_valid    = (q.ph == ST_EMIT);
    assign out_vector   = q.kvec[q.eidx];
    assign out_mask     = q.kmask[q.eidx];
    assign out_last     = (q.eidx == q.nkept - ONE);
    assign active_count = count;

    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_vector)
                                    && $stable(out_mask) && $stable(out_last));

    a_r7_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> !out_valid);

    a_r8_busy_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph != ST_IDLE) |=> $stable(active_count));

    a_r5_mask_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_mask != '0));

    a_r2_mask_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_mask & ~fen) == '0));
endmodule

// File: tb/sim_lut_fault_lister.sv
`timescale 1ns/1ps
module sim_lut_fault_lister;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [15:0] table_in = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_vector;
    logic [9:0]  out_mask;
    logic        out_last;
    logic [2:0]  active_count;

    int checks = 0;
    int errors = 0;

    logic [15:0] exp_vec [10];
    logic [9:0]  exp_mask [10];
    int          exp_n;
    logic [9:0]  got_mask [10];
    int          got_n;

    always #4 clk = ~clk;

    lut_fault_lister u0 (
        .clk(clk), .rst_n(rst_n), .load(load), .table_in(table_in),
        .out_valid(out_valid), .out_ready(out_ready), .out_vector(out_vector),
        .out_mask(out_mask), .out_last(out_last), .active_count(active_count)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int ref_active(input logic [15:0] t);
        int n = 0;
        for (int x = 0; x < 4; x++) begin
            logic a = 1'b0;
            for (int k = 0; k < 16; k++) if (t[k] != t[k ^ (1 << x)]) a = 1'b1;
            if (a) n++;
        end
        return n;
    endfunction

    function automatic logic in_active(input logic [15:0] t, input int x);
        for (int k = 0; k < 16; k++) if (t[k] != t[k ^ (1 << x)]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [15:0] ref_vec(input logic [15:0] t, input int f);
        logic [15:0] r;
        int x, v;
        if (f == 0) return 16'h0000;
        if (f == 1) return 16'hFFFF;
        x = (f - 2) / 2;
        v = (f - 2) % 2;
        for (int k = 0; k < 16; k++) r[k] = t[(k & ~(1 << x)) | (v << x)];
        return r;
    endfunction

    task automatic build_ref(input logic [15:0] t);
        exp_n = 0;
        for (int f = 0; f < 10; f++) begin
            logic [15:0] vv;
            logic found = 1'b0;
            if (f >= 2 && !in_active(t, (f - 2) / 2)) continue;
            vv = ref_vec(t, f);
            for (int j = 0; j < exp_n; j++) begin
                if (!found && exp_vec[j] == vv) begin
                    exp_mask[j][f] = 1'b1;
                    found = 1'b1;
                end
            end
            if (!found) begin
                exp_vec[exp_n]  = vv;
                exp_mask[exp_n] = 10'b0;
                exp_mask[exp_n][f] = 1'b1;
                exp_n++;
            end
        end
    endtask

    // One scenario: load t, optionally stall on the first entry, optionally inject a stray load
    task automatic run_case(input logic [15:0] t, input bit stall, input bit stray);
        int waitc = 0;
        int cnt0;
        build_ref(t);
        @(negedge clk);
        table_in = t;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        while (!out_valid && waitc < 50) begin
            @(negedge clk);
            waitc++;
        end
        check("R1 active_count", 32'(active_count), 32'(ref_active(t)));
        cnt0 = active_count;
        got_n = 0;
        for (int i = 0; i < exp_n; i++) begin
            check("R7 valid during stream", 32'(out_valid), 32'd1);
            check("R3/R4 vector", 32'(out_vector), 32'(exp_vec[i]));
            check("R2/R5/R6 mask", 32'(out_mask), 32'(exp_mask[i]));
            check("R7 last flag", 32'(out_last), 32'(i == exp_n - 1));
            got_mask[i] = out_mask;
            got_n++;
            if (stall && i == 0) begin
                logic [15:0] hv = out_vector;
                logic [9:0]  hm = out_mask;
                out_ready = 1'b0;
                for (int s = 0; s < 3; s++) begin
                    @(negedge clk);
                    check("R9 valid held", 32'(out_valid), 32'd1);
                    check("R9 vector held", 32'(out_vector), 32'(hv));
                    check("R9 mask held", 32'(out_mask), 32'(hm));
                end
                out_ready = 1'b1;
            end
            if (stray && i == 0) begin
                table_in = ~t;
                load = 1'b1;
            end
            @(negedge clk);
            load = 1'b0;
        end
        check("R7 valid drops after last", 32'(out_valid), 32'd0);
        if (stray) begin
            check("R8 active_count kept", 32'(active_count), 32'(cnt0));
            for (int s = 0; s < 15; s++) @(negedge clk);
            check("R8 no second stream", 32'(out_valid), 32'd0);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        check("R10 valid after reset", 32'(out_valid), 32'd0);
        check("R10 count after reset", 32'(active_count), 32'd0);
    endtask

    task automatic test_constants();
        run_case(16'h0000, 0, 0);
        check("R3 zero table entries", 32'(got_n), 32'd2);
        run_case(16'hFFFF, 0, 0);
        check("R2 constant table entries", 32'(got_n), 32'd2);
    endtask

    task automatic test_single_input();
        run_case(16'hAAAA, 0, 0);
        check("R6 i0 sa0 merges with out sa0", 32'(got_mask[0]), 32'h005);
        check("R6 i0 sa1 merges with out sa1", 32'(got_mask[1]), 32'h00A);
    endtask

    task automatic test_sum_of_products();
        logic [15:0] t;
        logic merged = 1'b0;
        for (int k = 0; k < 16; k++) t[k] = (k[3] & k[2]) | (k[1] & k[0]);
        run_case(t, 1, 0);
        for (int i = 0; i < got_n; i++) if (got_mask[i][8] && got_mask[i][6]) merged = 1'b1;
        check("R5 i3 sa0 and i2 sa0 merged", 32'(merged), 32'd1);
    endtask

    task automatic test_patterns();
        run_case(16'h6996, 0, 0);
        run_case(16'h8000, 1, 0);
        run_case(16'h00F0, 0, 0);
        run_case(16'h3C5A, 0, 0);
    endtask

    task automatic test_stray_load();
        run_case(16'hCA35, 0, 1);
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_constants();
        test_single_input();
        test_sum_of_products();
        test_patterns();
        test_stray_load();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule